// File: doc/BRIEF.md
# Width-Adapting Memory Write Router

This block accepts single write requests from an external agent. Each carries a physical address, a data word of up to 128 bits and a size code that selects a power-of-two byte count. The address is compared against a fixed table of four regions. A region is either RAM or a device. A RAM write goes out on a byte-enabled memory port, and the block marks the 4 KiB page it lands in as dirty. A device write goes out on a downstream valid/ready port, carrying the region index and the offset relative to the region base.

Each device region has a size-support mask. A 64-bit write to a device that lacks 64-bit support but does accept 32-bit accesses is turned into two ordered 32-bit writes. Any other size the device does not support is discarded quietly. A request that is illegal or unmapped finishes with an error status.

The dirty-page bits can be read and cleared one page at a time through a small side port. Software that copies or checkpoints memory can use it to find the pages that were written.

Top module: `mem_write_router`

## Requirements
- R1: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 finish with `rsp_err`=1 and cause no RAM write and no device write.
- R2: `req_ready` is high exactly when no device transfer is in progress. A request is taken on a cycle with `req_valid` and `req_ready` both high. An error, RAM or discarded request raises `rsp_valid` for one cycle, one cycle after it is taken.
- R3: Region i is hit when base_i <= addr < base_i + size_i. When regions overlap, the lowest index wins. An address that hits no region finishes with `rsp_err`=1.
- R4: A RAM write pulses `ram_we` for one cycle with `ram_addr` set to the region-relative offset. `ram_be` bits 0 to 2^n-1 are set and all others are clear. `ram_wdata` holds the low 2^n bytes of the data and zero above them. The status is 0.
- R5: A RAM write sets the dirty bit of page offset[15:12]. `dirty_bit` shows the bit of page `dirty_sel`. `dirty_clr` clears that page. If a set and a clear hit the same page in the same cycle, the set wins. Every bit is 0 after reset.
- R6: A device write whose size code n has bit n set in the region mask gives one downstream write. That write carries the same size, the full data, the offset and the region index. Status 0 follows once it is accepted.
- R7: For size 3 to a device with mask bit 3 clear and bit 2 set, two size-2 writes are issued. The first has data[31:0] at the offset. The second has data[63:32] at offset+4. Each data word is zero-extended. `req_ready` stays low until the second is accepted, and the response comes after that.
- R8: Any other unsupported device size gives no downstream write and no RAM write, and it finishes with `rsp_valid` and `rsp_err`=0.
- R9: While `dev_valid` is high and `dev_ready` is low, `dev_valid` and every downstream field hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request |
| req_addr | input | 32 | Physical byte address |
| req_size | input | 3 | Size code n, 2^n bytes |
| req_data | input | 128 | Write data, byte 0 in bits 7:0 |
| rsp_valid | output | 1 | Completion pulse |
| rsp_err | output | 1 | 1 when illegal size or unmapped |
| ram_we | output | 1 | RAM write strobe |
| ram_region | output | 2 | Region index of the RAM write |
| ram_addr | output | 32 | Region-relative byte offset |
| ram_be | output | 16 | Byte enables |
| ram_wdata | output | 128 | Masked write data |
| dev_valid | output | 1 | Device write present |
| dev_ready | input | 1 | Device accepts |
| dev_region | output | 2 | Target region index |
| dev_offset | output | 32 | Region-relative offset |
| dev_size | output | 3 | Size code of the device write |
| dev_data | output | 128 | Device write data |
| dirty_sel | input | 4 | Page selected on the side port |
| dirty_clr | input | 1 | Clear the selected page's dirty bit |
| dirty_bit | output | 1 | Dirty bit of the selected page |

## Verification
The hardest case to reach from the ports is a dirty-bit set and a side-port clear landing on the same page in the same cycle. To get there, the bench raises `dirty_clr` on the exact edge that takes a RAM request. A second hard case is the stall between the two halves of a split write. For that, the bench holds `dev_ready` low for a varying number of cycles before each half, while it checks that the fields stay steady and that the requester stays blocked. Every size code is swept against every region kind, overlap, both RAM edges and unmapped space.

// File: rtl/wr_pkg.sv
package wr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DEV,
        ST_SPLIT_LO,
        ST_SPLIT_HI
    } rt_state_e;

    typedef enum logic [2:0] {
        ACT_ERR,
        ACT_RAM,
        ACT_FWD,
        ACT_SPLIT,
        ACT_DROP
    } rt_action_e;

endpackage

// File: rtl/wr_region_decode.sv
module wr_region_decode #(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 4,
    parameter int MASK_W      = 5,
    parameter int IDX_W       = 2,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] BASE   = '0,
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] SPAN   = '0,
    parameter logic [NUM_REGIONS-1:0]             IS_RAM = '0,
    parameter logic [NUM_REGIONS-1:0][MASK_W-1:0] SUPP   = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              is_ram,
    output logic [MASK_W-1:0] supp,
    output logic [ADDR_W-1:0] offset
);

    logic [NUM_REGIONS-1:0]             match;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] rel;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        assign rel[g]   = addr - BASE[g];
        assign match[g] = (addr >= BASE[g]) && (rel[g] < SPAN[g]);
    end

    // scan downward so the lowest matching index is the last one written
    always_comb begin
        hit    = 1'b0;
        idx    = '0;
        is_ram = 1'b0;
        supp   = '0;
        offset = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit    = 1'b1;
                idx    = IDX_W'(i);
                is_ram = IS_RAM[i];
                supp   = SUPP[i];
                offset = rel[i];
            end
        end
    end

endmodule

// File: rtl/wr_lane_mask.sv
module wr_lane_mask #(
    parameter int DATA_W = 128,
    parameter int SIZE_W = 3,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic [SIZE_W-1:0] size,
    input  logic [DATA_W-1:0] din,
    output logic [NBYTES-1:0] be,
    output logic [DATA_W-1:0] dout
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        // lane b is live when b < 2^size
        assign be[b]             = ((32'(b) >> size) == 32'd0);
        assign dout[8*b +: 8]    = be[b] ? din[8*b +: 8] : 8'h00;
    end

endmodule

// File: rtl/wr_dirty_map.sv
module wr_dirty_map #(
    parameter int NUM_PAGES = 16,
    localparam int PG_IDX_W = $clog2(NUM_PAGES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [PG_IDX_W-1:0] set_idx,
    input  logic                clr_en,
    input  logic [PG_IDX_W-1:0] clr_idx,
    input  logic [PG_IDX_W-1:0] rd_idx,
    output logic                rd_bit
);

    logic [NUM_PAGES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clr_en) bits_d[clr_idx] = 1'b0;
        if (set_en) bits_d[set_idx] = 1'b1;   // a write beats a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign rd_bit = bits_q[rd_idx];

    a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> bits_q[$past(set_idx)]);

    a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !bits_q[$past(clr_idx)]);

endmodule

// File: rtl/mem_write_router.sv
module mem_write_router
    import wr_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 128,
    parameter int SIZE_W      = 3,
    parameter int NUM_REGIONS = 4,
    parameter int PAGE_W      = 12,
    parameter int NUM_PAGES   = 16,
    localparam int NBYTES     = DATA_W / 8,
    localparam int MAX_CODE   = $clog2(NBYTES),
    localparam int MASK_W     = MAX_CODE + 1,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int PG_IDX_W   = $clog2(NUM_PAGES),
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_BASE =
        {32'h2000_0000, 32'h1000_0000, 32'h1000_0000, 32'h8000_0000},
    parameter logic [NUM_REGIONS-1:0][ADDR_W-1:0] REGION_SPAN =
        {32'h0000_0100, 32'h0001_0000, 32'h0000_1000, 32'h0001_0000},
    parameter logic [NUM_REGIONS-1:0]             REGION_RAM  = 4'b0001,
    parameter logic [NUM_REGIONS-1:0][MASK_W-1:0] REGION_SUPP =
        {5'b00011, 5'b11111, 5'b00100, 5'b11111}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [SIZE_W-1:0]   req_size,
    input  logic [DATA_W-1:0]   req_data,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic                ram_we,
    output logic [IDX_W-1:0]    ram_region,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [NBYTES-1:0]   ram_be,
    output logic [DATA_W-1:0]   ram_wdata,
    output logic                dev_valid,
    input  logic                dev_ready,
    output logic [IDX_W-1:0]    dev_region,
    output logic [ADDR_W-1:0]   dev_offset,
    output logic [SIZE_W-1:0]   dev_size,
    output logic [DATA_W-1:0]   dev_data,
    input  logic [PG_IDX_W-1:0] dirty_sel,
    input  logic                dirty_clr,
    output logic                dirty_bit
);

    localparam int HALF_W = 32;
    localparam logic [SIZE_W-1:0] CODE_WORD   = SIZE_W'(2);
    localparam logic [SIZE_W-1:0] CODE_DWORD  = SIZE_W'(3);

    typedef struct packed {
        rt_state_e           st;
        logic                rsp_valid;
        logic                rsp_err;
        logic                ram_we;
        logic [IDX_W-1:0]    ram_region;
        logic [ADDR_W-1:0]   ram_addr;
        logic [NBYTES-1:0]   ram_be;
        logic [DATA_W-1:0]   ram_wdata;
        logic [IDX_W-1:0]    dev_region;
        logic [ADDR_W-1:0]   dev_offset;
        logic [SIZE_W-1:0]   dev_size;
        logic [DATA_W-1:0]   dev_data;
        logic [HALF_W-1:0]   hi_word;
    } rt_regs_t;

    rt_regs_t r_d, r_q;

    // ---------------- decode ----------------
    logic              dec_hit, dec_ram;
    logic [IDX_W-1:0]  dec_idx;
    logic [MASK_W-1:0] dec_supp;
    logic [ADDR_W-1:0] dec_off;

    wr_region_decode #(
        .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .MASK_W(MASK_W), .IDX_W(IDX_W),
        .BASE(REGION_BASE), .SPAN(REGION_SPAN), .IS_RAM(REGION_RAM), .SUPP(REGION_SUPP)
    ) i_decode (
        .addr(req_addr), .hit(dec_hit), .idx(dec_idx), .is_ram(dec_ram),
        .supp(dec_supp), .offset(dec_off)
    );

    logic [NBYTES-1:0] lane_be;
    logic [DATA_W-1:0] lane_data;

    wr_lane_mask #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) i_lanes (
        .size(req_size), .din(req_data), .be(lane_be), .dout(lane_data)
    );

    logic              size_ok;
    logic [MASK_W-1:0] size_onehot;
    rt_action_e        act;

    always_comb begin
        size_ok     = (req_size <= SIZE_W'(MAX_CODE));
        size_onehot = MASK_W'(1) << req_size;
        if (!size_ok || !dec_hit)
            act = ACT_ERR;
        else if (dec_ram)
            act = ACT_RAM;
        else if ((dec_supp & size_onehot) != '0)
            act = ACT_FWD;
        else if (req_size == CODE_DWORD && dec_supp[2] && DATA_W >= 2 * HALF_W)
            act = ACT_SPLIT;
        else
            act = ACT_DROP;
    end

    logic take;
    assign req_ready = (r_q.st == ST_IDLE);
    assign take      = req_valid && req_ready;

    // ---------------- next state ----------------
    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_err   = 1'b0;
        r_d.ram_we    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (act)
                        ACT_ERR: begin
                            r_d.rsp_valid = 1'b1;
                            r_d.rsp_err   = 1'b1;
                        end
                        ACT_RAM: begin
                            r_d.rsp_valid  = 1'b1;
                            r_d.ram_we     = 1'b1;
                            r_d.ram_region = dec_idx;
                            r_d.ram_addr   = dec_off;
                            r_d.ram_be     = lane_be;
                            r_d.ram_wdata  = lane_data;
                        end
                        ACT_FWD: begin
                            r_d.st         = ST_DEV;
                            r_d.dev_region = dec_idx;
                            r_d.dev_offset = dec_off;
                            r_d.dev_size   = req_size;
                            r_d.dev_data   = req_data;
                        end
                        ACT_SPLIT: begin
                            r_d.st         = ST_SPLIT_LO;
                            r_d.dev_region = dec_idx;
                            r_d.dev_offset = dec_off;
                            r_d.dev_size   = CODE_WORD;
                            r_d.dev_data   = DATA_W'(req_data[HALF_W-1:0]);
                            r_d.hi_word    = req_data[2*HALF_W-1:HALF_W];
                        end
                        default: begin
                            r_d.rsp_valid = 1'b1;
                        end
                    endcase
                end
            end
            ST_DEV, ST_SPLIT_HI: begin
                if (dev_ready) begin
                    r_d.st        = ST_IDLE;
                    r_d.rsp_valid = 1'b1;
                end
            end
            ST_SPLIT_LO: begin
                if (dev_ready) begin
                    r_d.st         = ST_SPLIT_HI;
                    r_d.dev_offset = r_q.dev_offset + ADDR_W'(4);
                    r_d.dev_data   = DATA_W'(r_q.hi_word);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_err    = r_q.rsp_err;
    assign ram_we     = r_q.ram_we;
    assign ram_region = r_q.ram_region;
    assign ram_addr   = r_q.ram_addr;
    assign ram_be     = r_q.ram_be;
    assign ram_wdata  = r_q.ram_wdata;
    assign dev_valid  = (r_q.st != ST_IDLE);
    assign dev_region = r_q.dev_region;
    assign dev_offset = r_q.dev_offset;
    assign dev_size   = r_q.dev_size;
    assign dev_data   = r_q.dev_data;

    // ---------------- dirty pages ----------------
    wr_dirty_map #(.NUM_PAGES(NUM_PAGES)) i_dirty (
        .clk(clk), .rst_n(rst_n),
        .set_en(take && act == ACT_RAM),
        .set_idx(dec_off[PAGE_W +: PG_IDX_W]),
        .clr_en(dirty_clr), .clr_idx(dirty_sel),
        .rd_idx(dirty_sel), .rd_bit(dirty_bit)
    );

    // ---------------- assertions ----------------
    a_r9_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid && !dev_ready) |=> (dev_valid && $stable(dev_offset) && $stable(dev_data)
                                       && $stable(dev_size) && $stable(dev_region)));

    a_r7_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SPLIT_LO && dev_ready) |=>
            (dev_valid && dev_size == CODE_WORD && dev_offset == $past(dev_offset) + ADDR_W'(4)));

    a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(take) || $past(dev_valid && dev_ready)));

    a_r4_lanes_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_be[0] && ((ram_be & (ram_be + NBYTES'(1))) == '0)));

    a_r1_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> !ram_we);

endmodule

// File: tb/test_mem_write_router.sv
module test_mem_write_router;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [2:0]   req_size = '0;
    logic [127:0] req_data = '0;
    logic         rsp_valid, rsp_err;
    logic         ram_we;
    logic [1:0]   ram_region;
    logic [31:0]  ram_addr;
    logic [15:0]  ram_be;
    logic [127:0] ram_wdata;
    logic         dev_valid;
    logic         dev_ready = 1'b0;
    logic [1:0]   dev_region;
    logic [31:0]  dev_offset;
    logic [2:0]   dev_size;
    logic [127:0] dev_data;
    logic [3:0]   dirty_sel = '0;
    logic         dirty_clr = 1'b0;
    logic         dirty_bit;

    always #5 clk = ~clk;

    mem_write_router i_mem_write_router (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .ram_we(ram_we), .ram_region(ram_region), .ram_addr(ram_addr),
        .ram_be(ram_be), .ram_wdata(ram_wdata),
        .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_region(dev_region),
        .dev_offset(dev_offset), .dev_size(dev_size), .dev_data(dev_data),
        .dirty_sel(dirty_sel), .dirty_clr(dirty_clr), .dirty_bit(dirty_bit)
    );

    // region table as the requirements describe it
    localparam logic [31:0] RB [4] = '{32'h8000_0000, 32'h1000_0000, 32'h1000_0000, 32'h2000_0000};
    localparam logic [31:0] RS [4] = '{32'h0001_0000, 32'h0000_1000, 32'h0001_0000, 32'h0000_0100};
    localparam bit          RR [4] = '{1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [4:0]  RM [4] = '{5'b11111, 5'b00100, 5'b11111, 5'b00011};

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_dirty [16];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int find_region(input logic [31:0] a);
        for (int i = 0; i < 4; i++)
            if (a >= RB[i] && (a - RB[i]) < RS[i]) return i;
        return -1;
    endfunction

    task automatic check_dirty_all(input string tag);
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            dirty_sel = 4'(p);
            #1;
            chk(dirty_bit == exp_dirty[p], "R5", $sformatf("%s dirty page %0d", tag, p),
                128'(dirty_bit), 128'(exp_dirty[p]));
        end
    endtask

    // one request, with a stall count for dev_ready and an optional clear at acceptance
    task automatic run_req(input logic [31:0] a, input logic [2:0] sz,
                           input logic [127:0] d, input int stall, input int clr_pg);
        int           reg_i;
        int           nb;
        bit           exp_err;
        int           exp_ram;
        int           exp_dev;
        logic [31:0]  off;
        logic [15:0]  e_be;
        logic [127:0] e_wd;
        logic [31:0]  e_off [2];
        logic [127:0] e_dat [2];
        logic [2:0]   e_sz  [2];
        int           got_ram;
        int           got_dev;
        int           rsp_cyc;
        bit           got_err;
        bit           stalled;
        int           wait_n;
        logic [31:0]  h_off;
        logic [127:0] h_dat;
        string        rq;

        reg_i   = find_region(a);
        off     = (reg_i >= 0) ? a - RB[reg_i] : 32'h0;
        exp_err = 1'b0; exp_ram = 0; exp_dev = 0;
        nb      = 1 << sz;
        e_be    = '0; e_wd = '0;
        if (sz > 3'd4 || reg_i < 0) begin
            exp_err = 1'b1;
            rq = (sz > 3'd4) ? "R1" : "R3";
        end else if (RR[reg_i]) begin
            exp_ram = 1;
            rq = "R4";
            for (int b = 0; b < 16; b++)
                if (b < nb) begin
                    e_be[b]       = 1'b1;
                    e_wd[8*b +: 8] = d[8*b +: 8];
                end
        end else if (RM[reg_i][sz]) begin
            exp_dev = 1; rq = "R6";
            e_off[0] = off; e_dat[0] = d; e_sz[0] = sz;
        end else if (sz == 3'd3 && RM[reg_i][2]) begin
            exp_dev = 2; rq = "R7";
            e_off[0] = off;     e_dat[0] = {96'h0, d[31:0]};  e_sz[0] = 3'd2;
            e_off[1] = off + 4; e_dat[1] = {96'h0, d[63:32]}; e_sz[1] = 3'd2;
        end else begin
            rq = "R8";
        end

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_data = d;
        if (clr_pg >= 0) begin
            dirty_sel = 4'(clr_pg);
            dirty_clr = 1'b1;
        end
        chk(req_ready == 1'b1, "R2", "ready when idle", 128'(req_ready), 128'(1));
        @(posedge clk);
        if (clr_pg >= 0 && !(exp_ram == 1 && off[15:12] == 4'(clr_pg)))
            exp_dirty[clr_pg] = 1'b0;
        if (exp_ram == 1) exp_dirty[off[15:12]] = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        dirty_clr = 1'b0;

        got_ram = 0; got_dev = 0; rsp_cyc = -1; got_err = 1'b0;
        stalled = 1'b0; wait_n = 0; h_off = '0; h_dat = '0;
        for (int cyc = 0; cyc < 60; cyc++) begin
            if (ram_we) begin
                got_ram++;
                chk(ram_addr == off, "R4", "ram_addr", 128'(ram_addr), 128'(off));
                chk(ram_be == e_be, "R4", "ram_be", 128'(ram_be), 128'(e_be));
                chk(ram_wdata == e_wd, "R4", "ram_wdata", ram_wdata, e_wd);
                chk(ram_region == 2'(reg_i), "R4", "ram_region", 128'(ram_region), 128'(reg_i));
            end
            if (stalled)
                chk(dev_valid && dev_offset == h_off && dev_data == h_dat, "R9",
                    "hold under stall", {dev_offset, dev_data[95:0]}, {h_off, h_dat[95:0]});
            if (dev_valid) begin
                chk(!req_ready, "R7", "requester held", 128'(req_ready), 128'(0));
                if (wait_n >= stall) begin
                    dev_ready = 1'b1;
                    stalled   = 1'b0;
                    wait_n    = 0;
                    if (got_dev < exp_dev) begin
                        chk(dev_offset == e_off[got_dev], rq, $sformatf("dev_offset #%0d", got_dev),
                            128'(dev_offset), 128'(e_off[got_dev]));
                        chk(dev_data == e_dat[got_dev], rq, $sformatf("dev_data #%0d", got_dev),
                            dev_data, e_dat[got_dev]);
                        chk(dev_size == e_sz[got_dev], rq, "dev_size",
                            128'(dev_size), 128'(e_sz[got_dev]));
                        chk(dev_region == 2'(reg_i), rq, "dev_region",
                            128'(dev_region), 128'(reg_i));
                    end
                    got_dev++;
                end else begin
                    dev_ready = 1'b0;
                    stalled   = 1'b1;
                    h_off     = dev_offset;
                    h_dat     = dev_data;
                    wait_n++;
                end
            end else begin
                dev_ready = 1'b0;
            end
            if (rsp_valid) begin
                rsp_cyc = cyc;
                got_err = rsp_err;
                break;
            end
            @(negedge clk);
        end
        dev_ready = 1'b0;

        chk(rsp_cyc >= 0, rq, "response seen", 128'(rsp_cyc), 128'(0));
        chk(got_err == exp_err, rq, "rsp_err", 128'(got_err), 128'(exp_err));
        chk(got_ram == exp_ram, rq, "ram write count", 128'(got_ram), 128'(exp_ram));
        chk(got_dev == exp_dev, rq, "dev write count", 128'(got_dev), 128'(exp_dev));
        if (exp_dev == 0)
            chk(rsp_cyc == 0, "R2", "response one cycle after accept", 128'(rsp_cyc), 128'(0));
    endtask

    localparam logic [31:0] ADDRS [9] = '{
        32'h8000_0000, 32'h8000_5FF3, 32'h8000_FFFF, 32'h8001_0000,
        32'h1000_0010, 32'h1000_3008, 32'h2000_0004, 32'h3000_0000, 32'h0FFF_FFFC
    };

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int p = 0; p < 16; p++) exp_dirty[p] = 1'b0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0 && ram_we == 1'b0 && dev_valid == 1'b0, "R2",
            "outputs idle in reset", {rsp_valid, ram_we, dev_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready after reset", 128'(req_ready), 128'(1));
        check_dirty_all("reset");

        // sweep every size code over each region kind and boundary address
        for (int ai = 0; ai < 9; ai++) begin
            for (int s = 0; s < 8; s++) begin
                logic [127:0] d;
                int k;
                k = ai * 8 + s;
                d = {32'h1122_3344 ^ 32'(k), 32'h5566_7788 + 32'(k),
                     32'h99AA_BBCC ^ (32'(k) << 4), 32'hDDEE_FF00 + 32'(k)};
                run_req(ADDRS[ai], 3'(s), d, (k % 3), -1);
            end
        end
        check_dirty_all("after sweep");

        // R5: clearing pages one by one
        for (int p = 0; p < 16; p++) begin
            @(negedge clk);
            dirty_sel = 4'(p);
            dirty_clr = 1'b1;
            exp_dirty[p] = 1'b0;
            @(negedge clk);
            dirty_clr = 1'b0;
        end
        check_dirty_all("after clear");

        // R5: set and clear of the same page in one cycle, set wins
        run_req(32'h8000_3010, 3'd2, 128'hCAFE, 0, 3);
        check_dirty_all("set beats clear");
        // R5: clear of another page in the same cycle as a set
        run_req(32'h8000_7000, 3'd0, 128'h5A, 0, 3);
        check_dirty_all("clear other page");

        // R7/R9: split with long stalls on both halves
        run_req(32'h1000_0FF8, 3'd3, 128'h0123_4567_89AB_CDEF, 4, -1);
        // R6: 16-byte forward with a long stall
        run_req(32'h1000_F000, 3'd4, {4{32'hA5A5_5A5A}}, 5, -1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule